// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Zero and Overflow Flags

This block is a purely combinational integer ALU for a datapath. It takes two operands and a three-bit function code. From these it returns a result word, a flag that is set when the result is zero, and a flag that reports signed overflow. It provides bitwise AND, bitwise OR, addition, subtraction and a signed less-than compare.

A single adder carries every arithmetic function. For subtraction the second operand is bit-inverted and the adder is given a carry-in of one. The compare takes its answer from that same subtraction and corrects for overflow, so it is right over the full signed range.

A multiplexer at the output picks the requested function. Function codes that are not defined give an all-zero result with no overflow.

Top module: `alu_core`

## Requirements
- R1: Function code 3'b000 drives the result with the bitwise AND of operands a and b.
- R2: Function code 3'b001 drives the result with the bitwise OR of operands a and b.
- R3: Function code 3'b010 drives the result with a + b modulo 2^WIDTH.
- R4: Function code 3'b110 drives the result with a - b modulo 2^WIDTH, which is a + ~b + 1.
- R5: Function code 3'b111 drives result bit 0 with 1 when a < b as two's complement numbers, and with 0 otherwise. All higher result bits are 0. The answer stays correct when a - b overflows.
- R6: The zero flag is 1 exactly when every result bit is 0, for every function code.
- R7: For codes 3'b010 and 3'b110, the overflow flag is 1 exactly when both adder inputs (a, and b or ~b) have the same most significant bit and the sum's most significant bit differs from it.
- R8: Function codes 3'b011, 3'b100 and 3'b101 give a result of 0 and an overflow flag of 0, so the zero flag is 1.
- R9: For codes 3'b000, 3'b001 and 3'b111, the overflow flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Function code |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | Selected function result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The hardest case to reach is a compare whose internal subtraction overflows. In that case the raw sign of the difference gives the wrong answer, and only the overflow correction makes it right. The vector table drives operand pairs at the ends of the signed range (most negative against one, most positive against most negative) to force the subtraction to wrap. It also drives the same pairs through plain subtraction, which shows the overflow flag. The zero flag is exercised for each way it can be reached: wrapped addition, equal-operand subtraction, undefined codes, and a false compare.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    FN_AND = 3'b000,
    FN_OR  = 3'b001,
    FN_ADD = 3'b010,
    FN_SUB = 3'b110,
    FN_SLT = 3'b111
  } alu_fn_e;
endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
    assign and_o[gi] = a_i[gi] & b_i[gi];
    assign or_o[gi]  = a_i[gi] | b_i[gi];
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             less_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    sum_o  = a_i + b_eff + WIDTH'(sub_i);
    ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    less_o = sum_o[MSB] ^ ovf_o;
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value_i,
  output logic             zero_o
);
  assign zero_o = ~(|value_i);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] and_w, or_w, sum_w;
  logic             add_ovf, add_less, do_sub;
  alu_fn_e          fn;

  assign fn     = alu_fn_e'(op_i);
  assign do_sub = op_i[2];

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i(a_i), .b_i(b_i), .and_o(and_w), .or_o(or_w)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(do_sub),
    .sum_o(sum_w), .ovf_o(add_ovf), .less_o(add_less)
  );

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    case (fn)
      FN_AND: result_o = and_w;
      FN_OR:  result_o = or_w;
      FN_ADD: begin result_o = sum_w; ovf_o = add_ovf; end
      FN_SUB: begin result_o = sum_w; ovf_o = add_ovf; end
      FN_SLT: result_o = {{(WIDTH-1){1'b0}}, add_less};
      default: begin result_o = '0; ovf_o = 1'b0; end
    endcase
  end

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value_i(result_o), .zero_o(zero_o)
  );
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);
  always_comb begin
    if (op_i == 3'b111) begin
      a_r5_slt_upper: assert final (result_o[WIDTH-1:1] == '0);
      a_r5_slt_signed: assert final (result_o[0] == ($signed(a_i) < $signed(b_i)));
    end
    if (op_i == 3'b010) begin
      a_r3_add_sum: assert final (result_o == a_i + b_i);
    end
    if (op_i == 3'b110) begin
      a_r4_sub_diff: assert final (result_o == a_i - b_i);
    end
    a_r6_zero_flag: assert final (zero_o == (result_o == '0));
    if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) begin
      a_r8_unlisted: assert final (result_o == '0 && !ovf_o);
    end
    if (op_i == 3'b000 || op_i == 3'b001 || op_i == 3'b111) begin
      a_r9_no_overflow: assert final (!ovf_o);
    end
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
);

// File: tb/test_alu_core.sv
module test_alu_core;
  localparam int W = 32;
  localparam int NV = 18;

  logic clk;
  logic rst_n;
  logic [2:0]   op;
  logic [W-1:0] a, b;
  logic [W-1:0] res;
  logic         zf, of;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // {op, a, b, expected result, expected overflow}
  localparam logic [99:0] VEC [NV] = '{
    {3'b000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0},
    {3'b000, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 1'b0},
    {3'b001, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 1'b0},
    {3'b001, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0},
    {3'b010, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b0},
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1},
    {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0},
    {3'b010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1},
    {3'b110, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b0},
    {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1},
    {3'b110, 32'h12345678, 32'h12345678, 32'h00000000, 1'b0},
    {3'b111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0},
    {3'b111, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 1'b0},
    {3'b111, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0},
    {3'b111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b0},
    {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0},
    {3'b100, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b0},
    {3'b101, 32'h80000000, 32'h80000000, 32'h00000000, 1'b0}
  };

  alu_core #(.WIDTH(W)) i_alu_core (
    .op_i(op), .a_i(a), .b_i(b),
    .result_o(res), .zero_o(zf), .ovf_o(of)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string req_of(input logic [2:0] code);
    case (code)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic string ovf_req_of(input logic [2:0] code);
    case (code)
      3'b010, 3'b110: return "R7";
      3'b000, 3'b001, 3'b111: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    op = 3'b000; a = '0; b = '0;
    @(negedge clk);
    // reset state: AND of zeros gives zero result and zero flag
    check("R1", "reset result", res, '0);
    check("R6", "reset zero", {31'b0, zf}, 32'd1);
    check("R9", "reset ovf", {31'b0, of}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0]   vo;
      logic [W-1:0] va, vb, vr;
      logic         vf;
      {vo, va, vb, vr, vf} = VEC[i];
      apply(vo, va, vb);
      check(req_of(vo), $sformatf("vec %0d result", i), res, vr);
      check("R6", $sformatf("vec %0d zero", i), {31'b0, zf}, {31'b0, (vr == '0)});
      check(ovf_req_of(vo), $sformatf("vec %0d ovf", i), {31'b0, of}, {31'b0, vf});
    end

    // directed: compare of equal operands is false (R5), zero flag high (R6)
    apply(3'b111, 32'h80000000, 32'h80000000);
    check("R5", "slt equal", res, '0);
    check("R6", "slt equal zero", {31'b0, zf}, 32'd1);
    // directed: subtract of negative minus positive max overflows (R7)
    apply(3'b110, 32'hFFFFFFFE, 32'h7FFFFFFF);
    check("R4", "sub wrap", res, 32'h7FFFFFFF);
    check("R7", "sub wrap ovf", {31'b0, of}, 32'd1);
    // directed: add of large negatives without overflow (R7)
    apply(3'b010, 32'hC0000000, 32'hC0000000);
    check("R3", "add neg", res, 32'h80000000);
    check("R7", "add neg ovf", {31'b0, of}, 32'd0);
    // directed: slt with subtraction overflow keeps upper bits clear (R5)
    apply(3'b111, 32'h80000000, 32'h7FFFFFFF);
    check("R5", "slt min vs max", res, 32'h00000001);
    check("R9", "slt ovf", {31'b0, of}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule